// File: doc/BRIEF.md
# Bridge Interrupt Capture and Timeout Unit

This unit collects the three interrupt causes of a bus bridge into a small register set and drives one combined interrupt line. The causes are a level from the bridge's interrupt source, a slave error indication from a function inside the bridge, and a built-in watchdog. The watchdog measures how long a transaction's data phase has been running and flags it when it stays open too long.

Software sees three 32-bit registers: a status register whose bits flip when written with 1, a read/write enable register, and a read-only pending register that shows the enabled status bits. The interrupt output is a registered OR of the pending bits. A per-transaction start/acknowledge pair drives the watchdog. The unit contains no bus protocol logic. It decodes only its three offsets.

Top module: `bridge_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the status, enable and pending registers read 0 and irq_out is 0.
- R2: Every register uses the same bit layout in the 32-bit data word. The bridge interrupt is data bit 2 (mask 0x4), the data-phase timeout is data bit 1 (mask 0x2) and the transaction error is data bit 0 (mask 0x1). In the most-significant-first numbering these are bits 29, 30 and 31. Data bits 31:3 always read 0, and any offset other than 0x0, 0x4 or 0x8 reads 0.
- R3: A write to offset 0x0 inverts each status bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: The enable register at offset 0x4 is read/write in data bits 2:0.
- R5: Offset 0x8 reads the bitwise AND of status and enable. Writes to 0x8 change no register.
- R6: If bridge_irq_in is high at a clock edge, that edge sets the bridge status bit. The bit stays set after the input falls.
- R7: If slv_err is high at a clock edge, that edge sets the error status bit. A timeout never sets the error bit.
- R8: If a hardware event and a software toggle hit the same bit in the same cycle, the bit ends at 1.
- R9: The clock edge that samples xfer_start high starts the watchdog. If no xfer_ack is sampled on any of the following 255 edges, the 255th of those edges sets the timeout bit. An xfer_ack on any of those edges, including the 255th, prevents it.
- R10: A watchdog that has fired stays quiet until the next xfer_start. An xfer_start while the watchdog is running restarts the 255-edge count.
- R11: irq_out equals the OR of the pending bits as they stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register (combinational) |
| bridge_irq_in | input | 1 | Bridge interrupt level |
| slv_err | input | 1 | Slave error indication from an internal function |
| xfer_start | input | 1 | Data phase begins |
| xfer_ack | input | 1 | Data phase completes |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench sweeps every status value against every toggle mask, and every status value against every enable value. A design with write-one-to-clear semantics, or one that gates pending wrongly, fails these sweeps at once.

The watchdog is tested at its exact edge. The timeout bit must still be 0 after 254 edges and 1 after the 255th. An acknowledge on the 255th edge must suppress the timeout. A counter that is off by one, or a compare that ignores a same-edge acknowledge, shows up here. The bench also checks that a fired watchdog stays quiet for a long time afterwards, and that a second start restarts the count.

A toggle that lands on the same edge as a hardware set must leave the bit at 1. irq_out is checked one edge after pending changes, to catch a version that is combinational or two cycles late.

// File: rtl/bridge_irq_pkg.sv
// Shared constants for the bridge interrupt unit: source bit indices and
// register offsets. Assumes a 32-bit data word and byte offsets.
package bridge_irq_pkg;
    localparam int NSRC       = 3;
    localparam int BIT_BRIDGE = 2;
    localparam int BIT_TMO    = 1;
    localparam int BIT_ERR    = 0;
    localparam logic [3:0] OFF_STAT = 4'h0;
    localparam logic [3:0] OFF_EN   = 4'h4;
    localparam logic [3:0] OFF_PEND = 4'h8;
    typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/dphase_watchdog.sv
// Data-phase watchdog. A start clears the count and arms the watchdog; each
// later edge without an acknowledge counts up. tmo_pulse is high for the one
// cycle whose edge is the TIMEOUT-th after the start. The watchdog then
// disarms until the next start. Assumes TIMEOUT >= 2.
module dphase_watchdog #(
    parameter int TIMEOUT = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack,
    output logic tmo_pulse
);
    localparam int CW = $clog2(TIMEOUT);

    logic          active;
    logic [CW-1:0] cnt;

    // Fires when the count has reached its last value and no ack or start is seen.
    assign tmo_pulse = active && !ack && !start && (cnt == CW'(TIMEOUT - 1));

    // Arm on start, disarm on ack or on timeout, otherwise count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (ack || tmo_pulse) active <= 1'b0;
            else                  cnt    <= cnt + 1'b1;
        end
    end

    assert_disarm_after_fire_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pulse |=> !active);
    assert_rearm_on_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (active && cnt == '0));
    assert_no_fire_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !start) |=> !tmo_pulse);
endmodule

// File: rtl/irq_status_reg.sv
// Status and enable storage. Status bits flip where the toggle mask holds a 1
// and are forced to 1 by hardware set events; a set wins over a toggle in the
// same cycle. The enable register is a plain load.
module irq_status_reg
    import bridge_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t hw_set,
    input  logic     tog_we,
    input  src_vec_t tog_mask,
    input  logic     en_we,
    input  src_vec_t en_wdata,
    output src_vec_t stat,
    output src_vec_t en
);
    src_vec_t stat_nxt;

    // Next status: software toggle first, then hardware sets take priority.
    always_comb begin
        stat_nxt = stat;
        if (tog_we) stat_nxt = stat_nxt ^ tog_mask;
        stat_nxt = stat_nxt | hw_set;
    end

    // Status register update.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= stat_nxt;
    end

    // Enable register update.
    always_ff @(posedge clk) begin
        if (!rst_n)     en <= '0;
        else if (en_we) en <= en_wdata;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_chk
        assert_hw_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hw_set[i] |=> stat[i]);
        assert_zero_mask_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (!hw_set[i] && !(tog_we && tog_mask[i])) |=> $stable(stat[i]));
    end
    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tog_we && hw_set == '0) |=> stat == ($past(stat) ^ $past(tog_mask)));
endmodule

// File: rtl/bridge_irq_unit.sv
// Bridge interrupt capture and timeout unit. Decodes three register offsets,
// captures the bridge interrupt, slave error and watchdog timeout events,
// forms pending = status & enable, and drives a registered combined interrupt.
// Assumes the register port is a single-cycle write strobe with a
// combinational read.
module bridge_irq_unit
    import bridge_irq_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 32,
    parameter int TIMEOUT = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              bridge_irq_in,
    input  logic              slv_err,
    input  logic              xfer_start,
    input  logic              xfer_ack,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFF_EN);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);

    logic     tmo_pulse;
    src_vec_t hw_set, stat, en, pend;
    logic     wr_stat, wr_en;

    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_en   = reg_wr && (reg_addr == A_EN);

    // Event sources mapped to their status bit positions.
    always_comb begin
        hw_set             = '0;
        hw_set[BIT_BRIDGE] = bridge_irq_in;
        hw_set[BIT_TMO]    = tmo_pulse;
        hw_set[BIT_ERR]    = slv_err;
    end

    dphase_watchdog #(.TIMEOUT(TIMEOUT)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (xfer_start),
        .ack       (xfer_ack),
        .tmo_pulse (tmo_pulse)
    );

    irq_status_reg u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .hw_set   (hw_set),
        .tog_we   (wr_stat),
        .tog_mask (reg_wdata[NSRC-1:0]),
        .en_we    (wr_en),
        .en_wdata (reg_wdata[NSRC-1:0]),
        .stat     (stat),
        .en       (en)
    );

    assign pend = stat & en;

    // Registered combined interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= 1'b0;
        else        irq_out <= |pend;
    end

    // Read multiplexer; unassigned bits and offsets read zero.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_STAT:  reg_rdata[NSRC-1:0] = stat;
            A_EN:    reg_rdata[NSRC-1:0] = en;
            A_PEND:  reg_rdata[NSRC-1:0] = pend;
            default: reg_rdata = '0;
        endcase
    end

    assert_irq_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == $past(|(stat & en)));
    assert_pend_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_PEND) |=> $stable(en));
    assert_tmo_not_error_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_pulse && !slv_err && !stat[BIT_ERR] && !(wr_stat && reg_wdata[BIT_ERR]))
            |=> !stat[BIT_ERR]);
    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:NSRC] == '0);
endmodule

// File: tb/sim_bridge_irq_unit.sv
module sim_bridge_irq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bridge_irq_in = 1'b0, slv_err = 1'b0, xfer_start = 1'b0, xfer_ack = 1'b0;
    logic        irq_out;
    int          errors = 0, checks = 0;
    logic [2:0]  cur;

    always #10 clk = ~clk;

    bridge_irq_unit u0 (.*);

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_stat(input logic [2:0] s);
        wr(4'h0, {29'h1fffffff, cur ^ s});
        cur = s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        cur = 3'b000;
        tick(3);
        rst_n = 1'b1;
        // R1 reset state
        rd(4'h0, d); check("R1 status", d, 0);
        rd(4'h4, d); check("R1 enable", d, 0);
        rd(4'h8, d); check("R1 pending", d, 0);
        check("R1 irq_out", {31'd0, irq_out}, 0);

        // R4 + R2 enable sweep with upper bits driven to 1
        for (int e = 0; e < 8; e++) begin
            wr(4'h4, 32'hfffffff8 | e);
            rd(4'h4, d); check("R4 R2 enable readback", d, e);
        end
        // R2 unused offsets
        rd(4'hc, d); check("R2 unused offset", d, 0);
        rd(4'h2, d); check("R2 unused offset", d, 0);

        // R3 exhaustive toggle sweep
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 8; w++) begin
                set_stat(s[2:0]);
                wr(4'h0, w);
                rd(4'h0, d); check("R3 toggle", d, s ^ w);
                cur = d[2:0];
            end
        end

        // R5 + R11 pending / irq sweep
        for (int s = 0; s < 8; s++) begin
            for (int e = 0; e < 8; e++) begin
                set_stat(s[2:0]);
                wr(4'h4, e);
                tick(1);
                rd(4'h8, d); check("R5 pending", d, s & e);
                check("R11 irq_out level", {31'd0, irq_out}, {31'd0, |(s & e)});
            end
        end

        // R11 latency: pending rises on edge E, irq_out on E+1
        set_stat(3'b000); wr(4'h4, 7); tick(1);
        check("R11 irq low", {31'd0, irq_out}, 0);
        wr(4'h0, 1); cur = 3'b001;
        check("R11 irq not yet", {31'd0, irq_out}, 0);
        tick(1);
        check("R11 irq one clock later", {31'd0, irq_out}, 1);

        // R5 write to pending ignored
        wr(4'h8, 32'hffffffff);
        rd(4'h0, d); check("R5 status after pend write", d, 1);
        rd(4'h4, d); check("R5 enable after pend write", d, 7);

        // R6 bridge interrupt capture
        set_stat(3'b000);
        bridge_irq_in = 1'b1; tick(1); bridge_irq_in = 1'b0; tick(2);
        rd(4'h0, d); check("R6 bridge bit captured", d, 32'h4);
        cur = 3'b100;
        // R7 slave error capture
        set_stat(3'b000);
        slv_err = 1'b1; tick(1); slv_err = 1'b0; tick(1);
        rd(4'h0, d); check("R7 error bit", d, 32'h1);
        cur = 3'b001;

        // R8 hw set beats toggle on a set bit
        set_stat(3'b101);
        reg_addr = 4'h0; reg_wdata = 32'h5; reg_wr = 1'b1;
        bridge_irq_in = 1'b1; slv_err = 1'b1;
        tick(1);
        reg_wr = 1'b0; bridge_irq_in = 1'b0; slv_err = 1'b0;
        rd(4'h0, d); check("R8 set wins", d, 32'h5);
        cur = 3'b101;

        // R9 exact timeout edge, R7 timeout leaves error clear
        set_stat(3'b000);
        xfer_start = 1'b1; tick(1); xfer_start = 1'b0;
        tick(254);
        rd(4'h0, d); check("R9 no timeout at 254", d, 0);
        tick(1);
        rd(4'h0, d); check("R9 R7 timeout at 255 only", d, 32'h2);
        cur = 3'b010;
        // R10 no retrigger
        set_stat(3'b000);
        tick(600);
        rd(4'h0, d); check("R10 no retrigger", d, 0);

        // R9 ack on the 255th edge suppresses
        xfer_start = 1'b1; tick(1); xfer_start = 1'b0;
        tick(254);
        xfer_ack = 1'b1; tick(1); xfer_ack = 1'b0;
        tick(300);
        rd(4'h0, d); check("R9 ack on last edge", d, 0);

        // R9 early ack
        xfer_start = 1'b1; tick(1); xfer_start = 1'b0;
        tick(10); xfer_ack = 1'b1; tick(1); xfer_ack = 1'b0;
        tick(400);
        rd(4'h0, d); check("R9 early ack", d, 0);

        // R10 restart mid-count
        xfer_start = 1'b1; tick(1); xfer_start = 1'b0;
        tick(200);
        xfer_start = 1'b1; tick(1); xfer_start = 1'b0;
        tick(254);
        rd(4'h0, d); check("R10 restart holds off", d, 0);
        tick(1);
        rd(4'h0, d); check("R10 restart fires at 255", d, 32'h2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule